// File: doc/BRIEF.md
# Memory-Mapped to Register-Bus Bridge

This block sits behind a fixed memory-mapped window and turns each 64-bit load or store that lands there into one access on an internal register bus. Several target units share that bus. The byte address is first cut down to the window and then folded into a register-bus address by a non-linear bit remap. A few hard-wired registers are served inside the bridge. These are a chip identification register and a list of fault and diagnostic registers. Every other address is matched against a table of address ranges, up to four per target. It is then forwarded to the winning target as an offset from that range's base, together with the range index.

The bridge does not answer a bad access with a bus error. It records the outcome of every transaction in a sticky two-bit status register: bit 0 means done and bit 1 means fail. Software clears that register with write-one-to-clear strobes. Each status bit can raise the interrupt line when its bit in a separate enable register is set. Only one access is in flight at a time. The requester waits for the response pulse before it issues the next access.

Top module: `regbus_bridge`

## Requirements
- R1: Bits of the byte address at and above the window width are ignored. Inside the window, with masked address `a`, the register-bus address is `((a >> 4) & ~0xF) | ((a >> 3) & 0xF)`. Byte-address bits 7 and 2..0 therefore have no effect.
- R2: An access whose size is not 8 bytes is never forwarded. It sets both done and fail, and a read returns zero.
- R3: A read of register-bus address 0xF000F returns the identification value 0x221EF04980000000 without forwarding. A write there is dropped. Both only set done.
- R4: Register-bus addresses 0x1010C00 to 0x1010C05, 0x2020007, 0x2020009, 0x202000F and 0x2013F00 to 0x2013F07 are served locally. Reads return zero, writes are dropped, nothing is forwarded, and only done is set.
- R5: Any other address that satisfies base <= addr < base + size for a configured range raises `bus_req` for that target only. It also presents `bus_offset` = addr - base, `bus_range` = the range index and `bus_write` = the access type.
- R6: When ranges overlap, the lowest-numbered target wins, and within it the lowest-numbered range.
- R7: An address that matches no range is not forwarded. It sets done and fail, and a read returns zero.
- R8: An access type the matched target does not support is not forwarded and fails. A target that answers with refuse also fails. Either failure sets done and fail, and a read returns zero. With the default configuration, target 2 accepts no writes.
- R9: Data is big-endian on the memory-mapped side. The most significant byte of a register value sits in `mmio_rdata[7:0]`, and `bus_wdata` / `bus_rdata` carry the byte-reversed memory-mapped value. An acknowledged access sets only done.
- R10: Status bits are ORed in and stay set. Setting `stat_clr_we` with `stat_clr_mask` clears the masked bits. When a completion and a clear touch the same bit in the same cycle, the bit ends set.
- R11: `irq` is high exactly when some status bit and its enable bit are both 1. The enable register is written through `en_we` / `en_wdata`.
- R12: For a local or failed access, `mmio_done` pulses in the cycle after the request. For a forwarded access, `bus_req` holds until the target answers, and `mmio_done` pulses in the cycle after that answer, together with the status update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mmio_valid | input | 1 | Request strobe, legal only when no access is outstanding |
| mmio_write | input | 1 | 1 = store, 0 = load |
| mmio_addr | input | ADDR_W | Byte address |
| mmio_size | input | 4 | Access size in bytes |
| mmio_wdata | input | 64 | Store data, big-endian |
| mmio_done | output | 1 | Response pulse |
| mmio_rdata | output | 64 | Load data, valid with `mmio_done` |
| bus_req | output | NUM_TGT | One request line per target, held until answered |
| bus_write | output | 1 | Access type on the register bus |
| bus_range | output | RI_W | Index of the matched range |
| bus_offset | output | BA_W | Offset from the range base |
| bus_wdata | output | 64 | Store data, native order |
| bus_ack | input | NUM_TGT | Single-cycle accept per target |
| bus_refuse | input | NUM_TGT | Single-cycle refuse per target |
| bus_rdata | input | NUM_TGT*64 | Load data lane per target |
| stat_clr_we | input | 1 | Clear strobe for the status register |
| stat_clr_mask | input | 2 | Status bits to clear |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | 2 | New enable value |
| status | output | 2 | Sticky status, bit 0 done, bit 1 fail |
| irq_en | output | 2 | Current enable register |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can meet on one clock edge: the completion logic ORing done or fail into the status register, and a software write-one-to-clear strobe. The bench provokes this on purpose by asserting the clear strobe in the same cycle as a local access. It does this first with fail already set and a full clear mask, so done must end set and fail must end cleared. The random phase then keeps issuing clears at request time while status updates arrive, and a bench model compares the status register after every response.

// File: rtl/regbus_pkg.sv
// Package: shared constants, state type and helper functions of the
// memory-mapped to register-bus bridge.
// Assumes register-bus addresses fit in 32 bits.
package regbus_pkg;

    localparam int          DATA_W       = 64;
    localparam logic [63:0] CHIP_ID_VAL  = 64'h221E_F049_8000_0000;
    localparam logic [31:0] CHIP_ID_ADDR = 32'h000F_000F;

    typedef enum logic {ST_IDLE, ST_WAIT} bstate_t;

    // Reverse byte order between the big-endian window and the native bus
    function automatic logic [63:0] bswap64(input logic [63:0] d);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = d[8*(7-i) +: 8];
        return r;
    endfunction

    // Fault and diagnostic registers answered locally with zero
    function automatic logic is_fixed_zero(input logic [31:0] a);
        return (a >= 32'h0101_0C00 && a <= 32'h0101_0C05) ||
               (a == 32'h0202_0007) || (a == 32'h0202_0009) ||
               (a == 32'h0202_000F) ||
               (a >= 32'h0201_3F00 && a <= 32'h0201_3F07);
    endfunction

endpackage

// File: rtl/regbus_addr_remap.sv
// Address remap: cuts the byte address down to the window and folds it into
// a register-bus address. Purely combinational.
// Assumes WIN_W > 8 and WIN_W <= ADDR_W.
module regbus_addr_remap #(
    parameter  int ADDR_W = 40,
    parameter  int WIN_W  = 32,
    localparam int BA_W   = WIN_W - 4
) (
    input  logic [ADDR_W-1:0] byte_addr,
    output logic [BA_W-1:0]   bus_addr
);
    localparam logic [ADDR_W-1:0] WIN_MASK = ADDR_W'((64'd1 << WIN_W) - 64'd1);

    logic [ADDR_W-1:0] masked;
    logic [ADDR_W-1:0] folded;

    // Drop bits outside the window, then merge the two shifted copies
    always_comb begin
        masked   = byte_addr & WIN_MASK;
        folded   = ((masked >> 4) & ~ADDR_W'(4'hF)) | ((masked >> 3) & ADDR_W'(4'hF));
        bus_addr = folded[BA_W-1:0];
    end

endmodule

// File: rtl/regbus_range_decode.sv
// Range decoder: compares a register-bus address against every configured
// range and picks the lowest target, then the lowest range, on overlap.
// Assumes a range of size zero is unused.
module regbus_range_decode #(
    parameter  int          BA_W    = 28,
    parameter  int          NUM_TGT = 3,
    parameter  int          NRNG    = 4,
    parameter  int unsigned RNG_BASE [NUM_TGT*NRNG] = '{default: 0},
    parameter  int unsigned RNG_SIZE [NUM_TGT*NRNG] = '{default: 0},
    localparam int          TI_W    = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1,
    localparam int          RI_W    = (NRNG > 1) ? $clog2(NRNG) : 1,
    localparam int          NENT    = NUM_TGT * NRNG
) (
    input  logic [BA_W-1:0] bus_addr,
    output logic            hit,
    output logic [TI_W-1:0] hit_tgt,
    output logic [RI_W-1:0] hit_rng,
    output logic [BA_W-1:0] hit_off
);
    logic [NENT-1:0] ent_hit;
    logic [BA_W-1:0] ent_off [NENT];

    for (genvar gi = 0; gi < NENT; gi++) begin : g_ent
        localparam logic [BA_W-1:0] BASE = BA_W'(RNG_BASE[gi]);
        localparam logic [BA_W:0]   SIZE = (BA_W+1)'(RNG_SIZE[gi]);
        // Offset and in-range test of one table entry
        assign ent_off[gi] = bus_addr - BASE;
        assign ent_hit[gi] = (SIZE != '0) && (bus_addr >= BASE) &&
                             ({1'b0, ent_off[gi]} < SIZE);
    end

    // Priority pick: scan downward so the lowest index wins
    always_comb begin
        hit     = 1'b0;
        hit_tgt = '0;
        hit_rng = '0;
        hit_off = '0;
        for (int i = NENT - 1; i >= 0; i--) begin
            if (ent_hit[i]) begin
                hit     = 1'b1;
                hit_tgt = TI_W'(i / NRNG);
                hit_rng = RI_W'(i % NRNG);
                hit_off = ent_off[i];
            end
        end
    end

endmodule

// File: rtl/regbus_status.sv
// Status and interrupt: sticky done/fail bits with write-one-to-clear, an
// enable register and the interrupt output. A set beats a clear.
module regbus_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_valid,
    input  logic       set_fail,
    input  logic       clr_we,
    input  logic [1:0] clr_mask,
    input  logic       en_we,
    input  logic [1:0] en_wdata,
    output logic [1:0] status_q,
    output logic [1:0] en_q,
    output logic       irq
);
    logic [1:0] set_bits;
    logic [1:0] keep_bits;

    // Bits raised by the completing access
    always_comb begin
        set_bits  = set_valid ? {set_fail, 1'b1} : 2'b00;
        keep_bits = status_q & ~({2{clr_we}} & clr_mask);
    end

    // Status register: clear first, then OR in new bits
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= 2'b00;
        else        status_q <= keep_bits | set_bits;
    end

    // Enable register
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 2'b00;
        else if (en_we) en_q <= en_wdata;
    end

    // Interrupt request from enabled status bits
    assign irq = |(status_q & en_q);

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & $past(keep_bits)) == $past(keep_bits)));
    p_done_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |=> status_q[0]);
    p_fail_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_valid && set_fail) |=> status_q[1]);

endmodule

// File: rtl/regbus_bridge.sv
// Memory-mapped to register-bus bridge top. Accepts one 8-byte access at a
// time, serves fixed registers locally, forwards the rest to the decoded
// target and reports every outcome in the sticky status register.
// Assumes mmio_valid is raised only while no access is outstanding.
module regbus_bridge
    import regbus_pkg::*;
#(
    parameter  int          ADDR_W  = 40,
    parameter  int          WIN_W   = 32,
    parameter  int          NUM_TGT = 3,
    parameter  int          NRNG    = 4,
    parameter  int unsigned RNG_BASE [NUM_TGT*NRNG] = '{
        32'h1000, 32'h2000, 32'h0,    32'h0,
        32'h2040, 32'h3000, 32'h0,    32'h0,
        32'h4000, 32'h5000, 32'h6000, 32'h6100},
    parameter  int unsigned RNG_SIZE [NUM_TGT*NRNG] = '{
        32'h100,  32'h80,   32'h0,    32'h0,
        32'h100,  32'h10,   32'h0,    32'h0,
        32'h40,   32'h40,   32'h8,    32'h8},
    parameter  logic [NUM_TGT-1:0] TGT_CAN_RD = '1,
    parameter  logic [NUM_TGT-1:0] TGT_CAN_WR = 3'b011,
    localparam int          BA_W    = WIN_W - 4,
    localparam int          TI_W    = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1,
    localparam int          RI_W    = (NRNG > 1) ? $clog2(NRNG) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mmio_valid,
    input  logic                    mmio_write,
    input  logic [ADDR_W-1:0]       mmio_addr,
    input  logic [3:0]              mmio_size,
    input  logic [63:0]             mmio_wdata,
    output logic                    mmio_done,
    output logic [63:0]             mmio_rdata,
    output logic [NUM_TGT-1:0]      bus_req,
    output logic                    bus_write,
    output logic [RI_W-1:0]         bus_range,
    output logic [BA_W-1:0]         bus_offset,
    output logic [63:0]             bus_wdata,
    input  logic [NUM_TGT-1:0]      bus_ack,
    input  logic [NUM_TGT-1:0]      bus_refuse,
    input  logic [NUM_TGT*64-1:0]   bus_rdata,
    input  logic                    stat_clr_we,
    input  logic [1:0]              stat_clr_mask,
    input  logic                    en_we,
    input  logic [1:0]              en_wdata,
    output logic [1:0]              status,
    output logic [1:0]              irq_en,
    output logic                    irq
);
    bstate_t         st_q;
    logic [TI_W-1:0] tgt_q;
    logic [BA_W-1:0] remap_addr;
    logic            dec_hit;
    logic [TI_W-1:0] dec_tgt;
    logic [RI_W-1:0] dec_rng;
    logic [BA_W-1:0] dec_off;
    logic            resp_now, fail_now, fwd_now, got_resp, refused;
    logic [63:0]     rdata_now, lane_rdata;

    regbus_addr_remap #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_remap (
        .byte_addr (mmio_addr),
        .bus_addr  (remap_addr)
    );

    regbus_range_decode #(
        .BA_W(BA_W), .NUM_TGT(NUM_TGT), .NRNG(NRNG),
        .RNG_BASE(RNG_BASE), .RNG_SIZE(RNG_SIZE)
    ) u_decode (
        .bus_addr (remap_addr),
        .hit      (dec_hit),
        .hit_tgt  (dec_tgt),
        .hit_rng  (dec_rng),
        .hit_off  (dec_off)
    );

    regbus_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_valid (resp_now),
        .set_fail  (fail_now),
        .clr_we    (stat_clr_we),
        .clr_mask  (stat_clr_mask),
        .en_we     (en_we),
        .en_wdata  (en_wdata),
        .status_q  (status),
        .en_q      (irq_en),
        .irq       (irq)
    );

    // Answer from the target currently being served
    always_comb begin
        got_resp   = |(bus_req & (bus_ack | bus_refuse));
        refused    = |(bus_req & bus_refuse);
        lane_rdata = bus_rdata[tgt_q*64 +: 64];
    end

    // Classify the incoming access or the pending target answer
    always_comb begin
        resp_now  = 1'b0;
        fail_now  = 1'b0;
        fwd_now   = 1'b0;
        rdata_now = '0;
        if (st_q == ST_IDLE && mmio_valid) begin
            resp_now = 1'b1;
            if (mmio_size != 4'd8) begin
                fail_now = 1'b1;
            end else if (32'(remap_addr) == CHIP_ID_ADDR) begin
                rdata_now = mmio_write ? 64'd0 : bswap64(CHIP_ID_VAL);
            end else if (is_fixed_zero(32'(remap_addr))) begin
                rdata_now = '0;
            end else if (!dec_hit ||
                         (mmio_write ? !TGT_CAN_WR[dec_tgt] : !TGT_CAN_RD[dec_tgt])) begin
                fail_now = 1'b1;
            end else begin
                resp_now = 1'b0;
                fwd_now  = 1'b1;
            end
        end else if (st_q == ST_WAIT && got_resp) begin
            resp_now  = 1'b1;
            fail_now  = refused;
            rdata_now = (refused || bus_write) ? 64'd0 : bswap64(lane_rdata);
        end
    end

    // Transaction state, bus request and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            tgt_q      <= '0;
            bus_req    <= '0;
            bus_write  <= 1'b0;
            bus_range  <= '0;
            bus_offset <= '0;
            bus_wdata  <= '0;
            mmio_done  <= 1'b0;
            mmio_rdata <= '0;
        end else begin
            mmio_done <= resp_now;
            if (resp_now) mmio_rdata <= rdata_now;
            if (fwd_now) begin
                st_q       <= ST_WAIT;
                tgt_q      <= dec_tgt;
                bus_req    <= NUM_TGT'(1) << dec_tgt;
                bus_write  <= mmio_write;
                bus_range  <= dec_rng;
                bus_offset <= dec_off;
                bus_wdata  <= bswap64(mmio_wdata);
            end else if (st_q == ST_WAIT && got_resp) begin
                st_q    <= ST_IDLE;
                bus_req <= '0;
            end
        end
    end

    p_req_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_req));
    p_req_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_req != '0) && !got_resp) |=> $stable(bus_req));
    p_done_no_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        mmio_done |-> (bus_req == '0));
    p_done_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mmio_done |-> status[0]);

endmodule

// File: tb/regbus_bridge_bench.sv
module regbus_bridge_bench;
    localparam int NT = 3;
    localparam int NR = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic             mmio_valid = 0, mmio_write = 0;
    logic [39:0]      mmio_addr = '0;
    logic [3:0]       mmio_size = 4'd8;
    logic [63:0]      mmio_wdata = '0;
    logic             mmio_done;
    logic [63:0]      mmio_rdata;
    logic [NT-1:0]    bus_req;
    logic             bus_write;
    logic [1:0]       bus_range;
    logic [27:0]      bus_offset;
    logic [63:0]      bus_wdata;
    logic [NT-1:0]    bus_ack = '0, bus_refuse = '0;
    logic [NT*64-1:0] bus_rdata = '0;
    logic             stat_clr_we = 0, en_we = 0;
    logic [1:0]       stat_clr_mask = '0, en_wdata = '0;
    logic [1:0]       status, irq_en;
    logic             irq;

    regbus_bridge u_regbus_bridge (.*);

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [1:0] exp_st = 2'b00, exp_en = 2'b00;
    logic [63:0] tmem [int];

    int unsigned tb_base [NT*NR] = '{32'h1000, 32'h2000, 0, 0, 32'h2040, 32'h3000, 0, 0,
                                     32'h4000, 32'h5000, 32'h6000, 32'h6100};
    int unsigned tb_size [NT*NR] = '{32'h100, 32'h80, 0, 0, 32'h100, 32'h10, 0, 0,
                                     32'h40, 32'h40, 8, 8};

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] bsw(input logic [63:0] d);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = d[8*(7-i) +: 8];
        return r;
    endfunction

    // R1 model: window is 32 bits, bus address 28 bits
    function automatic logic [27:0] remap(input logic [39:0] a);
        logic [31:0] m = a[31:0];
        return {m[31:8], m[6:3]};
    endfunction

    function automatic logic [39:0] to_byte(input logic [27:0] b, input logic [11:0] junk);
        return {junk[11:4], b[27:4], junk[3], b[3:0], junk[2:0]};
    endfunction

    function automatic bit is_local0(input logic [27:0] b);
        logic [31:0] a = 32'(b);
        return (a >= 32'h1010C00 && a <= 32'h1010C05) || a == 32'h2020007 ||
               a == 32'h2020009 || a == 32'h202000F || (a >= 32'h2013F00 && a <= 32'h2013F07);
    endfunction

    function automatic logic [63:0] mem_rd(input int key);
        if (tmem.exists(key)) return tmem[key];
        return {32'(key), ~32'(key)};
    endfunction

    // One access; the bench plays the target on the register bus
    task automatic xact(input bit wr, input logic [39:0] a, input logic [3:0] sz,
                        input logic [63:0] wd, input bit refuse,
                        input bit clr, input logic [1:0] cm, input string req);
        logic [27:0] b = remap(a);
        bit fwd = 0, fail = 0, hit = 0;
        int tg = 0, rg = 0;
        logic [27:0] off = '0;
        logic [63:0] exp_rd = '0;
        int key;
        for (int i = NT*NR-1; i >= 0; i--)
            if (tb_size[i] != 0 && 32'(b) >= tb_base[i] && 32'(b) - tb_base[i] < tb_size[i]) begin
                hit = 1; tg = i / NR; rg = i % NR; off = 28'(32'(b) - tb_base[i]);
            end
        if (sz != 4'd8) fail = 1;
        else if (32'(b) == 32'hF000F) exp_rd = wr ? 64'd0 : bsw(64'h221EF04980000000);
        else if (is_local0(b)) exp_rd = '0;
        else if (!hit || (wr && tg == 2)) fail = 1;
        else fwd = 1;
        key = tg * 4096 + rg * 1024 + int'(off);

        @(negedge clk);
        mmio_valid = 1; mmio_write = wr; mmio_addr = a; mmio_size = sz; mmio_wdata = wd;
        stat_clr_we = clr; stat_clr_mask = cm;
        if (clr) exp_st = exp_st & ~cm;
        @(negedge clk);
        mmio_valid = 0; stat_clr_we = 0;
        if (fwd) begin
            chk(bus_req == NT'(1 << tg), {req, " R5 req"}, 64'(bus_req), 64'(1 << tg));
            chk(bus_offset == off && bus_range == 2'(rg), {req, " R5 off/rng"},
                {bus_offset, 2'(bus_range)}, {off, 2'(rg)});
            chk(bus_write == wr, {req, " R5 type"}, 64'(bus_write), 64'(wr));
            if (wr) chk(bus_wdata == bsw(wd), {req, " R9 wdata"}, bus_wdata, bsw(wd));
            chk(mmio_done == 0, {req, " R12 early"}, 64'(mmio_done), 0);
            @(negedge clk);
            chk(bus_req == NT'(1 << tg), {req, " R12 hold"}, 64'(bus_req), 64'(1 << tg));
            if (refuse) begin bus_refuse[tg] = 1; fail = 1; end
            else begin
                bus_ack[tg] = 1;
                if (wr) tmem[key] = bsw(wd);
                else exp_rd = bsw(mem_rd(key));
            end
            bus_rdata[tg*64 +: 64] = mem_rd(key);
            @(negedge clk);
            bus_ack = '0; bus_refuse = '0;
        end else begin
            chk(bus_req == 0, {req, " R7 no forward"}, 64'(bus_req), 0);
        end
        exp_st = exp_st | (fail ? 2'b11 : 2'b01);
        chk(mmio_done == 1, {req, " R12 done"}, 64'(mmio_done), 1);
        if (!wr) chk(mmio_rdata == (fail ? 64'd0 : exp_rd), {req, " R9 rdata"}, mmio_rdata,
                     fail ? 64'd0 : exp_rd);
        chk(status == exp_st, {req, " R10 status"}, 64'(status), 64'(exp_st));
        chk(irq == |(exp_st & exp_en), {req, " R11 irq"}, 64'(irq), 64'(|(exp_st & exp_en)));
        @(negedge clk);
        chk(mmio_done == 0, {req, " R12 pulse"}, 64'(mmio_done), 0);
    endtask

    task automatic set_en(input logic [1:0] v);
        @(negedge clk); en_we = 1; en_wdata = v; exp_en = v;
        @(negedge clk); en_we = 0;
        chk(irq == |(exp_st & exp_en), "R11 enable", 64'(irq), 64'(|(exp_st & exp_en)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED1234);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(status == 0 && irq == 0 && mmio_done == 0 && bus_req == 0, "R10 reset",
            {status, irq, mmio_done, 60'(bus_req)}, 0);
        // R3 identification register, write dropped
        xact(0, 40'hAB_00F0_0078, 8, 0, 0, 0, 0, "R3 id read");
        xact(1, 40'h00_00F0_00F8, 8, 64'h1111, 0, 0, 0, "R3 id write");
        xact(0, 40'h00_00F0_0078, 8, 0, 0, 0, 0, "R3 id reread R1");
        // R4 local zero registers
        xact(1, to_byte(28'h1010C02, 12'h5A3), 8, 64'hFFFF, 0, 0, 0, "R4 local write");
        xact(0, to_byte(28'h2013F05, 12'h0F0), 8, 0, 0, 0, 0, "R4 local read");
        // R5/R6 decode and overlap
        xact(1, to_byte(28'h2050, 12'h000), 8, 64'h0102030405060708, 0, 0, 0, "R6 overlap wr");
        xact(0, to_byte(28'h2050, 12'hFFF), 8, 0, 0, 0, 0, "R6 overlap rd");
        xact(0, to_byte(28'h20C0, 12'h000), 8, 0, 0, 0, 0, "R5 t1 r0");
        xact(0, to_byte(28'h6104, 12'h321), 8, 0, 0, 0, 0, "R5 t2 r3");
        set_en(2'b01);
        // R7 miss, R2 size, R8 unsupported write and refuse
        xact(0, to_byte(28'h7000, 12'h000), 8, 0, 0, 0, 0, "R7 miss");
        xact(0, to_byte(28'h1010, 12'h000), 4, 0, 0, 0, 0, "R2 size4");
        xact(1, to_byte(28'h4010, 12'h000), 8, 64'h55, 0, 0, 0, "R8 no write");
        xact(0, to_byte(28'h1008, 12'h000), 8, 0, 1, 0, 0, "R8 refuse");
        set_en(2'b10);
        // R10 clear and completion on the same edge: done stays, fail clears
        xact(0, to_byte(28'h1010C00, 12'h000), 8, 0, 0, 1, 2'b11, "R10 set beats clear");
        chk(status == 2'b01 && irq == 0, "R10 R11 after clear", {status, irq}, {2'b01, 1'b0});
        for (int n = 0; n < 400; n++) begin
            int k = $urandom_range(0, 9);
            int e;
            logic [27:0] b;
            do e = $urandom_range(0, NT*NR-1); while (tb_size[e] == 0);
            b = 28'(tb_base[e] + $urandom_range(0, tb_size[e] - 1));
            if (k == 0) b = 28'($urandom_range(32'h7000, 32'hFFFF));
            if (k == 1) b = 28'h2020009;
            if (n % 37 == 0) set_en(2'($urandom_range(0, 3)));
            xact($urandom_range(0, 1), to_byte(b, 12'($urandom)), (k == 2) ? 4'd2 : 4'd8,
                 {$urandom, $urandom}, ($urandom_range(0, 7) == 0),
                 ($urandom_range(0, 3) == 0), 2'($urandom_range(0, 3)), "R1 random");
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule